// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block produces a single pulse-width modulated output. Its high time is taken from a small queue of 16-bit duty samples, and one sample is used for each PWM cycle. Software programs a period value and a prescaler through a small register bus, pushes duty samples into the queue, and then sets the enable. The counter advances once per prescaler tick. At the start of every cycle the block takes the next sample from the queue. When the queue has run dry, it holds the last sample.

A write to the sample register while the queue is full is discarded and raises a sticky write-error flag. While that flag is set, the output cannot run. A self-clearing software reset flushes the queue and clears the error, the control fields and the counters. It stays busy for a fixed number of clock cycles and ignores bus writes during that time. The low-power mode bits and the clock-source field are stored and read back only.

Top module: `fifo_pwm`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, the status register (offset 0x04) reads 0x08 (empty, level 0, no error) and the output is low.
- R2: Each write to the sample register (offset 0x0C, data bits [15:0]) queues one entry. Status bits [2:0] give the number of queued entries, and status bit 3 is 1 exactly when that number is 0.
- R3: A sample write while 4 entries are queued is dropped: the level stays 4 and status bit 4 (write error) becomes 1.
- R4: While status bit 4 is set, setting control bit 0 (enable) does not start the output: it stays low and no entry is consumed.
- R5: Writing status with bit 4 set clears the write error. With enable already set, the output then starts in the next cycle.
- R6: Writing control with bit 3 set starts a software reset. It flushes the queue, clears the error flag and all control fields, and makes control bit 3 read 1 for 4 clock cycles before it clears itself. Bus writes made during those cycles have no effect.
- R7: A PWM cycle lasts (period+1) counter steps, where period is the register at offset 0x10, bits [15:0]. The output is high while the step count is below the cycle's sample, and each new cycle consumes the next queued sample.
- R8: When a cycle starts with the queue empty, the previous sample is used again.
- R9: Control bits [15:4] hold the prescaler. Each counter step lasts (prescaler+1) clock cycles.
- R10: Control bits [24:22] and [17:16] are stored and read back, but they do not change the output or the queue. The period register reads back what was written.
- R11: While the output runs, the queue level falls by exactly one at the start of each PWM cycle. The first entry is taken one clock after the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle rd_i is high, zero otherwise |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench pushes a fifth sample into a full queue. A design that accepted it, or that let the error flag stop nothing, would show a level of 5 or wrap back to 0, or would pulse the output after enable. The queue level is sampled on the exact clock where a cycle boundary should pop an entry, which exposes a pop that comes a cycle early or late and a drain of more than one entry per cycle. The software-reset test reads the busy bit just before and just after it should clear, and it pushes a sample while the reset is busy to catch a design that still accepts writes. Full waveform captures over several cycles, with the queue running dry and with a prescaler above zero, catch off-by-one errors in the compare, in the wrap point and in the tick divider.

// File: rtl/fifo_pwm_pkg.sv
`timescale 1ns/1ps
package fifo_pwm_pkg;
  localparam logic [4:0] ADDR_CTRL = 5'h00;
  localparam logic [4:0] ADDR_STAT = 5'h04;
  localparam logic [4:0] ADDR_SAMP = 5'h0C;
  localparam logic [4:0] ADDR_PER  = 5'h10;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_SWR   = 3;
  localparam int STAT_EMPTY = 3;
  localparam int STAT_WERR  = 4;
  localparam int PRE_W      = 12;

  typedef struct packed {
    logic [2:0]       lp;   // low-power mode bits, storage only
    logic [1:0]       src;  // clock source code, storage only
    logic [PRE_W-1:0] pre;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/fifo_pwm_fifo.sv
`timescale 1ns/1ps
module fifo_pwm_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_nxt(wptr_q);
      if (do_pop)  rptr_q <= ptr_nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wptr_q] <= din_i;
  end
endmodule

// File: rtl/fifo_pwm_core.sv
`timescale 1ns/1ps
module fifo_pwm_core #(
  parameter int DW    = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [DW-1:0]    per_i,
  input  logic             avail_i,
  input  logic [DW-1:0]    head_i,
  output logic             pop_o,
  output logic [DW-1:0]    duty_o,
  output logic             pwm_o
);
  logic             active_q;
  logic [PRE_W-1:0] pc_q;
  logic [DW-1:0]    cnt_q, duty_q;
  logic             tick, wrap, load;

  // active_q marks that the first sample of a run has been taken
  assign tick   = active_q && (pc_q >= pre_i);
  assign wrap   = tick && (cnt_q >= per_i);
  assign load   = run_i && (!active_q || wrap);
  assign pop_o  = load && avail_i;
  assign pwm_o  = active_q && (cnt_q < duty_q);
  assign duty_o = duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pc_q     <= '0;
      cnt_q    <= '0;
      duty_q   <= '0;
    end else if (!run_i) begin
      active_q <= 1'b0;
      pc_q     <= '0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      pc_q     <= '0;
      cnt_q    <= '0;
      if (avail_i) duty_q <= head_i;
    end else begin
      pc_q <= tick ? '0 : pc_q + PRE_W'(1);
      if (tick) cnt_q <= wrap ? '0 : cnt_q + DW'(1);
      if (wrap && avail_i) duty_q <= head_i;
    end
  end
endmodule

// File: rtl/fifo_pwm.sv
`timescale 1ns/1ps
module fifo_pwm
  import fifo_pwm_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DEPTH      = 4,
  parameter int SWR_CYCLES = 4,
  localparam int LW        = $clog2(DEPTH + 1),
  localparam int CW        = $clog2(SWR_CYCLES + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        pwm_o
);
  ctrl_t         ctrl_q;
  logic          wr_err_q;
  logic [CW-1:0] swr_cnt_q;
  logic [DW-1:0] per_q;
  logic          swr_busy, wr_ok, run;
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0] fifo_head, duty;
  logic [LW-1:0] fifo_level;
  logic [31:0]   rd_ctrl, rd_stat, rd_mux;
  logic          unused_wdata;

  assign unused_wdata = ^{wdata_i[31:25], wdata_i[21:18]};

  assign swr_busy  = (swr_cnt_q != '0);
  assign wr_ok     = wr_i && !swr_busy;
  assign fifo_push = wr_ok && (addr_i == ADDR_SAMP) && !fifo_full;
  assign run       = ctrl_q.en && !wr_err_q && !swr_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      wr_err_q  <= 1'b0;
      swr_cnt_q <= '0;
      per_q     <= '0;
    end else if (swr_busy) begin
      swr_cnt_q <= swr_cnt_q - CW'(1);
      wr_err_q  <= 1'b0;
    end else if (wr_ok) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          if (wdata_i[CTRL_SWR]) begin
            ctrl_q    <= '0;
            swr_cnt_q <= CW'(SWR_CYCLES);
          end else begin
            ctrl_q.en  <= wdata_i[CTRL_EN];
            ctrl_q.pre <= wdata_i[15:4];
            ctrl_q.src <= wdata_i[17:16];
            ctrl_q.lp  <= wdata_i[24:22];
          end
        end
        ADDR_STAT: if (wdata_i[STAT_WERR]) wr_err_q <= 1'b0;
        ADDR_SAMP: if (fifo_full) wr_err_q <= 1'b1;
        ADDR_PER:  per_q <= wdata_i[DW-1:0];
        default: ;
      endcase
    end
  end

  fifo_pwm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (swr_busy),
    .push_i  (fifo_push),
    .din_i   (wdata_i[DW-1:0]),
    .pop_i   (fifo_pop),
    .head_o  (fifo_head),
    .level_o (fifo_level),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  fifo_pwm_core #(.DW(DW), .PRE_W(PRE_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .pre_i   (ctrl_q.pre),
    .per_i   (per_q),
    .avail_i (!fifo_empty),
    .head_i  (fifo_head),
    .pop_o   (fifo_pop),
    .duty_o  (duty),
    .pwm_o   (pwm_o)
  );

  always_comb begin
    rd_ctrl              = '0;
    rd_ctrl[CTRL_EN]     = ctrl_q.en;
    rd_ctrl[CTRL_SWR]    = swr_busy;
    rd_ctrl[15:4]        = ctrl_q.pre;
    rd_ctrl[17:16]       = ctrl_q.src;
    rd_ctrl[24:22]       = ctrl_q.lp;
    rd_stat              = '0;
    rd_stat[LW-1:0]      = fifo_level;
    rd_stat[STAT_EMPTY]  = fifo_empty;
    rd_stat[STAT_WERR]   = wr_err_q;
    rd_mux               = '0;
    unique case (addr_i)
      ADDR_CTRL: rd_mux = rd_ctrl;
      ADDR_STAT: rd_mux = rd_stat;
      ADDR_SAMP: rd_mux[DW-1:0] = duty;
      ADDR_PER:  rd_mux[DW-1:0] = per_q;
      default:   rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_i ? rd_mux : '0;
endmodule

// File: rtl/fifo_pwm_chk.sv
`timescale 1ns/1ps
module fifo_pwm_chk
  import fifo_pwm_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [4:0]    addr_i,
  input logic [LW-1:0] level_i,
  input logic          wr_err_i,
  input logic          busy_i,
  input logic          pwm_i
);
  // R3
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LW'(DEPTH));

  // R3
  full_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_i && addr_i == ADDR_SAMP && level_i == LW'(DEPTH)) |=> wr_err_i);

  // R4
  err_holds_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_err_i && $past(wr_err_i)) |-> !pwm_i);

  // R6
  swr_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (level_i == '0 && !wr_err_i));

  // R11
  single_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_i) |-> (int'(level_i) + 1 >= int'($past(level_i))));
endmodule

bind fifo_pwm fifo_pwm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .level_i  (fifo_level),
  .wr_err_i (wr_err_q),
  .busy_i   (swr_busy),
  .pwm_i    (pwm_o)
);

// File: tb/fifo_pwm_tb.sv
`timescale 1ns/1ps
module fifo_pwm_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pwm_o;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SAMP = 5'h0C, A_PER = 5'h10;

  always #2.5 clk_i = ~clk_i;

  fifo_pwm u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  // called at a negedge; combinational read, no clock consumed
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  function automatic logic [31:0] stat(input int lvl, input bit err);
    return 32'(lvl) | ((lvl == 0) ? 32'h8 : 32'h0) | (err ? 32'h10 : 32'h0);
  endfunction

  function automatic logic model(input int t, input int p, input int per,
                                 input int s0, input int s1, input int s2, input int n);
    int cl, j, c, d;
    cl = (per + 1) * (p + 1);
    j  = t / cl;
    c  = (t % cl) / (p + 1);
    if (j >= n) j = n - 1;
    d  = (j == 0) ? s0 : (j == 1) ? s1 : s2;
    return c < d;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk_i);
    rd(A_CTRL, d); check(d == 32'h0, "R1", "ctrl after reset", d, 0);
    rd(A_STAT, d); check(d == 32'h8, "R1", "status after reset", d, 32'h8);
    check(pwm_o == 1'b0, "R1", "pwm after reset", pwm_o, 0);
  endtask

  task automatic t_fill_overflow();
    logic [31:0] d;
    wr(A_SAMP, 2); wr(A_SAMP, 4); wr(A_SAMP, 6);
    rd(A_STAT, d); check(d == stat(3, 0), "R2", "level after 3 pushes", d, stat(3, 0));
    wr(A_SAMP, 8);
    rd(A_STAT, d); check(d == stat(4, 0), "R2", "level after 4 pushes", d, stat(4, 0));
    wr(A_SAMP, 9);
    rd(A_STAT, d); check(d == stat(4, 1), "R3", "fifth push dropped, error set", d, stat(4, 1));
  endtask

  task automatic t_err_blocks();
    logic [31:0] d;
    bit hi = 1'b0;
    wr(A_PER, 9);
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (pwm_o) hi = 1'b1;
    end
    check(!hi, "R4", "pwm stayed low with error", hi, 0);
    rd(A_STAT, d); check(d == stat(4, 1), "R4", "no entry consumed", d, stat(4, 1));
  endtask

  task automatic t_clear_release();
    logic [31:0] d;
    wr(A_STAT, 32'h10);
    rd(A_STAT, d); check(d == stat(4, 0), "R5", "error cleared by write-one", d, stat(4, 0));
    @(negedge clk_i);
    check(pwm_o == 1'b1, "R5", "pwm starts after clear", pwm_o, 1);
    rd(A_STAT, d); check(d == stat(3, 0), "R11", "first pop one clock after start", d, stat(3, 0));
    repeat (9) @(negedge clk_i);
    rd(A_STAT, d); check(d == stat(3, 0), "R11", "no pop before cycle end", d, stat(3, 0));
    @(negedge clk_i);
    rd(A_STAT, d); check(d == stat(2, 0), "R11", "one pop at cycle boundary", d, stat(2, 0));
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, d); check(d[3] == 1'b1, "R6", "reset bit busy", d, 32'h8);
    repeat (2) @(negedge clk_i);
    rd(A_CTRL, d); check(d[3] == 1'b1, "R6", "reset bit busy at cycle 3", d, 32'h8);
    wr(A_SAMP, 5);
    rd(A_CTRL, d); check(d == 32'h0, "R6", "reset bit self-cleared, ctrl cleared", d, 0);
    rd(A_STAT, d); check(d == stat(0, 0), "R6", "queue flushed, write ignored", d, stat(0, 0));
    check(pwm_o == 1'b0, "R6", "pwm low after reset", pwm_o, 0);
  endtask

  task automatic t_wave(input int p, input int per, input int s0, input int s1,
                        input int s2, input int n, input int len, input string req);
    logic [63:0] got = '0, exp = '0;
    wr(A_PER, per);
    wr(A_SAMP, s0);
    if (n > 1) wr(A_SAMP, s1);
    if (n > 2) wr(A_SAMP, s2);
    wr(A_CTRL, (p << 4) | 1);
    for (int t = 0; t < len; t++) begin
      @(negedge clk_i);
      got[t] = pwm_o;
      exp[t] = model(t, p, per, s0, s1, s2, n);
    end
    check(got == exp, req, "waveform", got, exp);
    wr(A_CTRL, 32'h8);
    repeat (6) @(negedge clk_i);
  endtask

  task automatic t_readback();
    logic [31:0] d, v;
    v = (32'h1 << 24) | (32'h1 << 22) | (32'h2 << 16) | (32'hABC << 4);
    wr(A_CTRL, v);
    rd(A_CTRL, d); check(d == v, "R10", "ctrl stored bits", d, v);
    rd(A_STAT, d); check(d == stat(0, 0), "R10", "status unaffected", d, stat(0, 0));
    check(pwm_o == 1'b0, "R10", "pwm unaffected", pwm_o, 0);
    wr(A_PER, 32'h1234);
    rd(A_PER, d); check(d == 32'h1234, "R10", "period readback", d, 32'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_fill_overflow();
    t_err_blocks();
    t_clear_release();
    t_soft_reset();
    t_wave(0, 9, 3, 5, 7, 3, 50, "R7 R8");
    t_wave(1, 3, 1, 3, 0, 2, 24, "R9 R8");
    t_readback();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule